// File: doc/BRIEF.md
# Mixed-Width Dual-Clock RAM

This block is a simple dual-port memory with one shared storage array and two ports of different widths, each on its own clock. The write side accepts full 64-bit words on the write clock. The read side runs on an unrelated read clock and returns 16-bit slices of those same words. Each 64-bit word therefore appears on the read side as four consecutive narrow addresses.

The narrow read does not use a vendor mixed-width memory. The block reads a full word from the array into a register on the read clock. A small multiplexer then picks one 16-bit lane from that register. The lane index is registered in the same cycle as the word, so the multiplexer always selects from the word that was just read. This keeps the whole structure in plain, portable code that a tool can infer.

Both data paths use valid/ready. The write side never pushes back while it is out of reset. On the read side, a request is taken only when the response slot is free or being emptied in the same cycle. A response that is not taken stays on the outputs, unchanged.

Top module: `mwram_dc`

## Requirements
- R1: A write is taken on a rising `wr_clk` edge when `wr_valid` and `wr_ready` are both high. It stores all 64 bits of `wr_data` at word `wr_addr`.
- R2: On the read side, `rd_addr[8:2]` selects the stored word and `rd_addr[1:0]` selects the lane. Lane 0 is bits 15:0, lane 1 is bits 31:16, lane 2 is bits 47:32 and lane 3 is bits 63:48.
- R3: A read request is taken on a rising `rd_clk` edge when `rd_valid` and `rd_ready` are both high. On that same edge, `rsp_valid` goes high and `rsp_data` carries the requested lane, so the latency is one read-clock cycle.
- R4: `rd_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values and no request is taken.
- R5: When a response is taken (`rsp_valid` and `rsp_ready` both high) and no new request is taken on the same edge, `rsp_valid` falls on that edge.
- R6: While `rd_rst_n` is low, `rsp_valid` is low. While `wr_rst_n` is low, `wr_ready` is low. Reset does not clear the contents of the array.
- R7: A cycle with `wr_valid` low leaves the array unchanged, whatever `wr_addr` and `wr_data` hold.
- R8: A later write to the same word replaces all four of its lanes.
- R9: With `rsp_ready` held high, the read side takes one request on every `rd_clk` cycle. Each response appears on the edge that takes the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write side can take a request (high while out of reset) |
| wr_addr | input | 7 | Wide word address |
| wr_data | input | 64 | Wide word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read side can take a request |
| rd_addr | input | 9 | Narrow address: word in 8:2, lane in 1:0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Selected 16-bit lane |

## Verification
The assertions assume three things about the inputs. The two clocks are free-running. Each reset is asserted from time zero, and a domain's properties are disabled while its reset is low. The read side never fetches a word that the write side is changing in the same period, because the result of such a collision is undefined. The stimulus meets the last point by keeping the domains apart in time. Every write sequence finishes, and several read-clock cycles pass, before any read of the affected words starts. Reads never overlap a write burst.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  localparam int unsigned MW_DEF_WR_W   = 64;
  localparam int unsigned MW_DEF_WR_AW  = 7;
  localparam int unsigned MW_DEF_LANES  = 4;

  function automatic int unsigned mw_lane_bits(input int unsigned lanes);
    return (lanes <= 1) ? 1 : $clog2(lanes);
  endfunction
endpackage

// File: rtl/mwram_store.sv
module mwram_store #(
  parameter int unsigned WR_W  = 64,
  parameter int unsigned WR_AW = 7
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [WR_AW-1:0] wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic [WR_AW-1:0] rd_addr,
  output logic [WR_W-1:0]  rd_word
);
  localparam int unsigned DEPTH = 1 << WR_AW;

  logic [WR_W-1:0] mem [DEPTH];

  // full-word write on the write clock
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered wide read on the read clock; holds when not enabled
  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/mwram_lane_sel.sv
module mwram_lane_sel #(
  parameter int unsigned WR_W  = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned RD_W = WR_W / LANES,
  localparam int unsigned LB   = mwram_pkg::mw_lane_bits(LANES)
) (
  input  logic [WR_W-1:0] word,
  input  logic [LB-1:0]   sel,
  output logic [RD_W-1:0] lane
);
  logic [RD_W-1:0] slices [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign slices[g] = word[g*RD_W +: RD_W];
  end

  assign lane = slices[sel];
endmodule

// File: rtl/mwram_rd_ctrl.sv
module mwram_rd_ctrl #(
  parameter int unsigned LB = 2
) (
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_valid,
  input  logic [LB-1:0] rd_lane,
  input  logic          rsp_ready,
  output logic          rd_ready,
  output logic          rd_take,
  output logic          rsp_valid,
  output logic [LB-1:0] lane_q
);
  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_take  = rd_valid && rd_ready;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rsp_valid <= 1'b0;
    end else if (rd_take) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // lane index captured alongside the wide word
  always_ff @(posedge rd_clk) begin
    if (rd_take) lane_q <= rd_lane;
  end
endmodule

// File: rtl/mwram_dc.sv
module mwram_dc
  import mwram_pkg::*;
#(
  parameter int unsigned WR_W  = MW_DEF_WR_W,
  parameter int unsigned WR_AW = MW_DEF_WR_AW,
  parameter int unsigned LANES = MW_DEF_LANES,
  localparam int unsigned LB    = mw_lane_bits(LANES),
  localparam int unsigned RD_W  = WR_W / LANES,
  localparam int unsigned RD_AW = WR_AW + LB
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WR_AW-1:0] wr_addr,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [RD_AW-1:0] rd_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RD_W-1:0]  rsp_data
);
  logic            wr_en;
  logic            rd_take;
  logic [LB-1:0]   lane_q;
  logic [WR_W-1:0] word_q;

  assign wr_ready = wr_rst_n;
  assign wr_en    = wr_valid && wr_ready;

  mwram_store #(.WR_W(WR_W), .WR_AW(WR_AW)) u_store (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_en   (rd_take),
    .rd_addr (rd_addr[RD_AW-1:LB]),
    .rd_word (word_q)
  );

  mwram_rd_ctrl #(.LB(LB)) u_ctrl (
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_valid  (rd_valid),
    .rd_lane   (rd_addr[LB-1:0]),
    .rsp_ready (rsp_ready),
    .rd_ready  (rd_ready),
    .rd_take   (rd_take),
    .rsp_valid (rsp_valid),
    .lane_q    (lane_q)
  );

  mwram_lane_sel #(.WR_W(WR_W), .LANES(LANES)) u_sel (
    .word (word_q),
    .sel  (lane_q),
    .lane (rsp_data)
  );
endmodule

// File: rtl/mwram_dc_chk.sv
module mwram_dc_chk #(
  parameter int unsigned RD_W = 16
) (
  input logic            rd_clk,
  input logic            rd_rst_n,
  input logic            wr_rst_n,
  input logic            wr_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [RD_W-1:0] rsp_data
);
  p_take_lat_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  p_stall_hold_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_stall_block_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);

  p_drain_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rsp_valid && rsp_ready && !rd_valid) |=> !rsp_valid);

  p_free_ready_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rsp_valid |-> rd_ready);

  // R6: reset state of the handshake outputs
  always @(negedge rd_clk) begin
    if (!rd_rst_n) p_rst_idle_r6: assert (!rsp_valid);
    if (!wr_rst_n) p_wr_rst_r6: assert (!wr_ready);
  end
endmodule

bind mwram_dc mwram_dc_chk #(.RD_W(RD_W)) u_chk (
  .rd_clk    (rd_clk),
  .rd_rst_n  (rd_rst_n),
  .wr_rst_n  (wr_rst_n),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/mwram_dc_bench.sv
`timescale 1ns/1ps
module mwram_dc_bench;
  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        wr_valid = 0, rd_valid = 0, rsp_ready = 1;
  logic [6:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic        wr_ready, rd_ready, rsp_valid;
  logic [15:0] rsp_data;

  logic [63:0] ref_mem [128];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 wr_clk = ~wr_clk;     // 250 MHz
  always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

  mwram_dc u_mwram_dc (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic logic [15:0] exp_lane(input logic [8:0] a);
    return ref_mem[a[8:2]][a[1:0]*16 +: 16];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [63:0] d);
    @(negedge wr_clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 0;
    ref_mem[a] = d;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic rd_one(input logic [8:0] a, input string req);
    @(negedge rd_clk);
    rsp_ready = 1; rd_valid = 1; rd_addr = a;
    chk(req, rd_ready, 1);
    @(negedge rd_clk);
    rd_valid = 0;
    chk(req, rsp_valid, 1);
    chk(req, rsp_data, exp_lane(a));
  endtask

  task automatic t_reset();
    chk("R6 rsp_valid in reset", rsp_valid, 0);
    chk("R6 wr_ready in reset", wr_ready, 0);
    repeat (3) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    chk("R6 wr_ready after reset", wr_ready, 1);
    chk("R4 rd_ready idle", rd_ready, 1);
    chk("R6 rsp_valid idle", rsp_valid, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 128; i++)
      wr_word(7'(i), {16'(i*4+3) ^ 16'hA000, 16'(i*4+2) ^ 16'h5000,
                      16'(i*4+1) ^ 16'hC000, 16'(i*4) ^ 16'h3000});
    settle();
  endtask

  task automatic t_read_all();  // R1 R2 R3
    for (int i = 0; i < 512; i++) rd_one(9'(i), "R2 lane read");
    @(negedge rd_clk);
    chk("R5 drop after take", rsp_valid, 0);
  endtask

  task automatic t_lane_order();  // R2 explicit positions
    wr_word(7'd5, 64'h4444_3333_2222_1111);
    settle();
    rd_one(9'd20, "R2 lane0=15:0");
    chk("R2 lane0 value", rsp_data, 16'h1111);
    rd_one(9'd23, "R2 lane3=63:48");
    chk("R2 lane3 value", rsp_data, 16'h4444);
  endtask

  task automatic t_no_write();  // R7
    @(negedge wr_clk);
    wr_valid = 0; wr_addr = 7'd9; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
    repeat (6) @(negedge wr_clk);
    settle();
    for (int l = 0; l < 4; l++) rd_one(9'(9*4 + l), "R7 idle write ignored");
  endtask

  task automatic t_overwrite();  // R8
    wr_word(7'd77, 64'h0123_4567_89AB_CDEF);
    wr_word(7'd77, 64'hFEDC_BA98_7654_3210);
    settle();
    for (int l = 0; l < 4; l++) rd_one(9'(77*4 + l), "R8 overwrite all lanes");
  endtask

  task automatic t_stall();  // R4 R5
    logic [15:0] held;
    @(negedge rd_clk);
    rsp_ready = 0; rd_valid = 1; rd_addr = 9'd41;
    @(negedge rd_clk);
    rd_addr = 9'd302;
    chk("R3 stalled resp valid", rsp_valid, 1);
    chk("R3 stalled resp data", rsp_data, exp_lane(9'd41));
    held = rsp_data;
    chk("R4 rd_ready low in stall", rd_ready, 0);
    repeat (3) @(negedge rd_clk);
    chk("R4 held valid", rsp_valid, 1);
    chk("R4 held data", rsp_data, held);
    rsp_ready = 1;
    @(negedge rd_clk);
    rd_valid = 0;
    chk("R4 next after release", rsp_data, exp_lane(9'd302));
    chk("R4 next valid", rsp_valid, 1);
    @(negedge rd_clk);
    chk("R5 drained", rsp_valid, 0);
  endtask

  task automatic t_burst();  // R9
    for (int i = 0; i <= 40; i++) begin
      @(negedge rd_clk);
      rsp_ready = 1;
      if (i > 0) begin
        chk("R9 burst valid", rsp_valid, 1);
        chk("R9 burst data", rsp_data, exp_lane(9'(100 + (i-1)*7)));
        chk("R9 ready each cycle", rd_ready, 1);
      end
      rd_valid = (i < 40);
      rd_addr = 9'(100 + i*7);
    end
    @(negedge rd_clk);
    chk("R5 burst end", rsp_valid, 0);
  endtask

  task automatic t_mid_reset();  // R6 contents survive
    @(negedge rd_clk);
    wr_rst_n = 0; rd_rst_n = 0;
    @(negedge rd_clk);
    chk("R6 rsp_valid reset", rsp_valid, 0);
    chk("R6 wr_ready reset", wr_ready, 0);
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
    rd_one(9'd21, "R6 contents kept");
    rd_one(9'd500, "R6 contents kept");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read_all();
    t_lane_order();
    t_no_write();
    t_overwrite();
    t_stall();
    t_burst();
    t_mid_reset();
    done = 1;
    finish_run();
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule